// File: doc/BRIEF.md
# Retriggerable Multimode Tracking Timer

This block is the sequencing core of a controller that switches a light or other load in step with the mains. A divided oscillator sets a tracking time. A qualified trigger, gated by an enable level, starts that time. The block drives two outputs. The first, an output-enable, turns the power stage on or off. The second, a stage select, chooses between the maximum conduction angle and the angle set by the user. The oscillator, the ramp, the phase-angle generation and the comparators sit outside the block. They reach it only as a tick, a zero-crossing strobe and logic levels.

The tracking time is 2048 counter steps. Each step takes a programmable number of oscillator ticks. A two-bit select picks one of three behaviours:
- a static zero-voltage switch, fully on for the tracking time;
- a two-stage dimmer that drops to the user angle at three quarters of the time and then switches off;
- a two-stage dimmer whose load also follows the enable input.

Every change of the outputs is held as a pending request and applied on a zero-crossing strobe. A power-good input acts as a soft reset. Each time power becomes good, the block runs exactly one cycle on its own.

Top module: `track_timer_top`

## Requirements
- R1: While `rst_n` or `pwr_good` is sampled low, the outputs are cleared at that edge, no run is active, and triggers and strobes have no effect.
- R2: Apart from R1, `out_en` and `stage_full` change only at a clock edge where `zc_strobe` is high. They then take the request registered at the previous edge.
- R3: One tracking time is 2048 counter steps. One step is `prescale`+1 cycles with `osc_tick` high. Cycles with `osc_tick` low do not advance the time.
- R4: With `mode_sel` = 2'b01 (static switch), a run drives `out_en`=1 and `stage_full`=1 for the whole tracking time. At expiry both outputs go to 0.
- R5: With `mode_sel` = 2'b10 or 2'b00, a run starts at full angle (`stage_full`=1). After 1536 steps the request becomes reduced angle (`stage_full`=0, `out_en`=1).
- R6: With `mode_sel` = 2'b10, the request becomes off when 2048 steps have elapsed.
- R7: With `mode_sel` = 2'b00 (2'b11 decodes the same), `enable_lvl` high alone requests on at reduced angle. `enable_lvl` low during a triggered run aborts the run and requests off.
- R8: A trigger during a run restarts the tracking time from zero, at full angle in the two-stage modes.
- R9: A `trig_pulse` counts only when `enable_lvl` is high in the same cycle. Otherwise it is ignored.
- R10: At the first edge where `pwr_good` is high after reset or after a power-good drop, exactly one run starts without any trigger. No other run starts without a trigger.
- R11: `stage_full` is never 1 while `out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply valid; when low, acts as a soft reset and re-arms the power-up run |
| osc_tick | input | 1 | One-cycle time-base tick from the oscillator |
| zc_strobe | input | 1 | One-cycle mains zero-crossing strobe |
| trig_pulse | input | 1 | Qualified trigger pulse |
| enable_lvl | input | 1 | Enable level, ANDed with the trigger; in 2'b00 mode it also drives the load |
| mode_sel | input | 2 | 00 two-stage follow-enable, 01 static switch, 10 two-stage with switch-off, 11 as 00 |
| prescale | input | PRE_W | Ticks per counter step minus one |
| out_en | output | 1 | Power stage on |
| stage_full | output | 1 | 1 selects maximum conduction angle, 0 the user angle |

## Verification
Let E be the edge that samples a trigger or the rising power-good. After edge E+n the counter holds n steps. The request register copies that state at the following edge, and a strobe applies it one edge later. A strobe sampled at edge E+k therefore shows the state reached after E+k-2.

The bench applies this rule at both boundaries of the run:
- strobes at E+1537 and E+1538 fall on either side of the angle change;
- strobes at E+2049 and E+2050 fall on either side of expiry.

A power-good drop is checked one edge after it is sampled. Random strobe positions are kept at least four edges away from either boundary.

// File: rtl/trk_pkg.sv
// Package trk_pkg
// Shared mode type and the decoder from the two-bit select.
// Assumes the select is static while a run is being checked.
package trk_pkg;

    typedef enum logic [1:0] {
        MODE_FOLLOW = 2'b00,
        MODE_STATIC = 2'b01,
        MODE_SWOFF  = 2'b10,
        MODE_SPARE  = 2'b11
    } trk_mode_e;

    // Map the raw select to a mode; the spare code behaves as follow-enable
    function automatic trk_mode_e decode_mode(input logic [1:0] sel);
        case (sel)
            2'b01:   return MODE_STATIC;
            2'b10:   return MODE_SWOFF;
            default: return MODE_FOLLOW;
        endcase
    endfunction

endpackage

// File: rtl/trk_count.sv
// Module trk_count
// Step prescaler plus DIV_W-bit tracking counter. Flags a run in progress
// and the last quarter of the tracking time.
// Assumes start and abort are single-cycle requests; start wins.
module trk_count #(
    parameter int DIV_W = 11,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             start,
    input  logic             abort,
    input  logic             osc_tick,
    input  logic [PRE_W-1:0] prescale,
    output logic             running,
    output logic             late
);

    localparam logic [DIV_W-1:0] TERM     = {DIV_W{1'b1}};
    localparam int unsigned      LATE_INT = 3 * (2 ** (DIV_W - 2));
    localparam logic [DIV_W-1:0] LATE_AT  = LATE_INT[DIV_W-1:0];
    localparam logic [DIV_W-1:0] CNT_ONE  = {{(DIV_W-1){1'b0}}, 1'b1};
    localparam logic [PRE_W-1:0] PRE_ONE  = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             run_q;
    logic             step_due;

    // A step completes when the prescaler reaches the programmed limit
    always_comb step_due = (pre_q == prescale);

    // Advance prescaler and counter; stop the run after the terminal step
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            cnt_q <= '0;
            pre_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            pre_q <= '0;
            run_q <= 1'b1;
        end else if (abort) begin
            cnt_q <= '0;
            pre_q <= '0;
            run_q <= 1'b0;
        end else if (run_q && osc_tick) begin
            if (step_due) begin
                pre_q <= '0;
                if (cnt_q == TERM) begin
                    cnt_q <= '0;
                    run_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_ONE;
                end
            end else begin
                pre_q <= pre_q + PRE_ONE;
            end
        end
    end

    // Run flag and three-quarter comparison
    always_comb begin
        running = run_q;
        late    = run_q && (cnt_q >= LATE_AT);
    end

endmodule

// File: rtl/trk_seq.sv
// Module trk_seq
// Mode sequencer: forms start and abort requests and the desired output
// state. Also owns the one-shot power-up run.
// Assumes running and late come from trk_count on the same clock.
module trk_seq (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  trk_pkg::trk_mode_e mode,
    input  logic              trig_pulse,
    input  logic              enable_lvl,
    input  logic              running,
    input  logic              late,
    output logic              start,
    output logic              abort,
    output logic              want_on,
    output logic              want_full,
    output logic              boot_pending
);

    import trk_pkg::*;

    logic boot_q;
    logic boot_run_q;
    logic trig_ok;

    // Power-up run is armed by reset or a supply drop and fires once
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) boot_q <= 1'b1;
        else                     boot_q <= 1'b0;
    end

    // Remember whether the active run is the power-up one (exempt from abort)
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) boot_run_q <= 1'b0;
        else if (start)          boot_run_q <= boot_q;
        else if (!running)       boot_run_q <= 1'b0;
    end

    // Start and abort requests for the counter
    always_comb begin
        trig_ok = trig_pulse && enable_lvl;
        start   = pwr_good && (boot_q || trig_ok);
        abort   = pwr_good && (mode == MODE_FOLLOW) && !enable_lvl &&
                  running && !boot_run_q && !start;
    end

    // Desired output state per mode
    always_comb begin
        case (mode)
            MODE_STATIC: begin
                want_on   = running;
                want_full = running;
            end
            MODE_SWOFF: begin
                want_on   = running;
                want_full = running && !late;
            end
            default: begin
                want_on   = running || enable_lvl;
                want_full = running && !late;
            end
        endcase
    end

    always_comb boot_pending = boot_q;

endmodule

// File: rtl/trk_zc_gate.sv
// Module trk_zc_gate
// Holds the pending output request and applies it only on a zero-crossing
// strobe.
// Assumes the strobe is one cycle wide.
module trk_zc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic zc_strobe,
    input  logic want_on,
    input  logic want_full,
    output logic out_en,
    output logic stage_full
);

    logic req_on_q;
    logic req_full_q;
    logic out_q;
    logic full_q;

    // Register the pending request every cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            req_on_q   <= 1'b0;
            req_full_q <= 1'b0;
        end else begin
            req_on_q   <= want_on;
            req_full_q <= want_on && want_full;
        end
    end

    // Apply the pending request at a zero crossing
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            out_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (zc_strobe) begin
            out_q  <= req_on_q;
            full_q <= req_full_q;
        end
    end

    always_comb begin
        out_en     = out_q;
        stage_full = full_q;
    end

endmodule

// File: rtl/track_timer_top.sv
// Module track_timer_top
// Retriggerable multimode tracking timer: counter, mode sequencer and
// zero-crossing output gate.
// Assumes all inputs are synchronous to clk.
module track_timer_top #(
    parameter int DIV_W = 11,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             osc_tick,
    input  logic             zc_strobe,
    input  logic             trig_pulse,
    input  logic             enable_lvl,
    input  logic [1:0]       mode_sel,
    input  logic [PRE_W-1:0] prescale,
    output logic             out_en,
    output logic             stage_full
);

    trk_pkg::trk_mode_e mode_w;
    logic running_w;
    logic late_w;
    logic start_w;
    logic abort_w;
    logic want_on_w;
    logic want_full_w;
    logic boot_pending_w;

    // Decode the mode select
    always_comb mode_w = trk_pkg::decode_mode(mode_sel);

    trk_count #(
        .DIV_W (DIV_W),
        .PRE_W (PRE_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .start    (start_w),
        .abort    (abort_w),
        .osc_tick (osc_tick),
        .prescale (prescale),
        .running  (running_w),
        .late     (late_w)
    );

    trk_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .mode         (mode_w),
        .trig_pulse   (trig_pulse),
        .enable_lvl   (enable_lvl),
        .running      (running_w),
        .late         (late_w),
        .start        (start_w),
        .abort        (abort_w),
        .want_on      (want_on_w),
        .want_full    (want_full_w),
        .boot_pending (boot_pending_w)
    );

    trk_zc_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .zc_strobe  (zc_strobe),
        .want_on    (want_on_w),
        .want_full  (want_full_w),
        .out_en     (out_en),
        .stage_full (stage_full)
    );

endmodule

// File: rtl/trk_timer_checker.sv
// Module trk_timer_checker
// Temporal properties of the tracking timer, attached to the top by bind.
module trk_timer_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic zc_strobe,
    input logic trig_pulse,
    input logic enable_lvl,
    input logic out_en,
    input logic stage_full,
    input logic running,
    input logic late,
    input logic start,
    input logic abort,
    input logic boot_pending
);

    // R1: a power-good drop clears the outputs at the next edge
    assert_pwr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!out_en && !stage_full));

    // R2: outputs move only on a zero-crossing strobe
    assert_zc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !zc_strobe) |=> ($stable(out_en) && $stable(stage_full)));

    // R5: once in the last quarter, a run stays there until it ends or restarts
    assert_late_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && running && late && !start && !abort) |=> (late || !running));

    // R9: a trigger without enable does not start an idle counter
    assert_trig_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !boot_pending && !running && trig_pulse && !enable_lvl) |=> !running);

    // R10: the power-up run cannot be re-armed while power stays good
    assert_single_boot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !boot_pending) |=> !boot_pending);

    // R11: reduced/full select is only meaningful while on
    assert_stage_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !stage_full);

endmodule

bind track_timer_top trk_timer_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .zc_strobe    (zc_strobe),
    .trig_pulse   (trig_pulse),
    .enable_lvl   (enable_lvl),
    .out_en       (out_en),
    .stage_full   (stage_full),
    .running      (running_w),
    .late         (late_w),
    .start        (start_w),
    .abort        (abort_w),
    .boot_pending (boot_pending_w)
);

// File: tb/track_timer_top_bench.sv
// Bench for track_timer_top: directed corner cases plus seeded random
// strobe positions, checked against a bench-side timing model.
module track_timer_top_bench;

    logic       clk = 1'b0;
    logic       rst_n, pwr_good, osc_tick, zc_strobe, trig_pulse, enable_lvl;
    logic [1:0] mode_sel;
    logic [7:0] prescale;
    logic       out_en, stage_full;

    int n_chk = 0;
    int n_bad = 0;
    int el    = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    track_timer_top u_track_timer_top (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .osc_tick(osc_tick),
        .zc_strobe(zc_strobe), .trig_pulse(trig_pulse), .enable_lvl(enable_lvl),
        .mode_sel(mode_sel), .prescale(prescale),
        .out_en(out_en), .stage_full(stage_full)
    );

    // Expected {on, full} for a strobe at edge E+k, no abort, prescale 0
    function automatic logic [1:0] exp_out(input logic [1:0] m, input int k, input logic en);
        int   c;
        logic run, late;
        c    = k - 2;
        run  = (c <= 2047);
        late = (c >= 1536);
        case (m)
            2'b01:   return {run, run};
            2'b10:   return {run, run && !late};
            default: return {run || en, run && !late};
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        n_chk++;
        if ({out_en, stage_full} !== exp) begin
            n_bad++;
            $display("FAIL %s: got on=%0b full=%0b expected on=%0b full=%0b",
                     req, out_en, stage_full, exp[1], exp[0]);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            el++;
        end
    endtask

    // Strobe sampled at edge E+k; returns at the negedge after it
    task automatic zc_at(input int k);
        while (el < k - 1) begin
            @(negedge clk);
            el++;
        end
        zc_strobe = 1'b1;
        @(negedge clk);
        el++;
        zc_strobe = 1'b0;
    endtask

    task automatic start_run();
        trig_pulse = 1'b1;
        @(negedge clk);
        trig_pulse = 1'b0;
        el = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [1:0] m;
        int k;
        void'($urandom(32'd2718));
        rst_n = 1'b0; pwr_good = 1'b0; osc_tick = 1'b1; zc_strobe = 1'b0;
        trig_pulse = 1'b0; enable_lvl = 1'b0; mode_sel = 2'b01; prescale = 8'd0;
        repeat (3) @(negedge clk);
        check("R1 reset", 2'b00);
        rst_n = 1'b1;
        enable_lvl = 1'b1;
        start_run();                       // ignored: power not good
        zc_at(el + 5);
        check("R1 ignored while power low", 2'b00);
        enable_lvl = 1'b0;

        // R10/R4: power-up run in static mode with no trigger
        pwr_good = 1'b1;
        @(negedge clk);
        el = 0;
        zc_at(10);
        check("R10 boot run on", 2'b11);
        zc_at(2040);
        check("R4 static full late in run", 2'b11);
        zc_at(2060);
        check("R4 static off at expiry", 2'b00);
        step(3000);
        zc_at(el + 3);
        check("R10 no second run", 2'b00);
        start_run();                       // enable low: R9
        zc_at(6);
        check("R9 trigger without enable", 2'b00);

        // R5/R6 exact boundaries in switch-off mode
        mode_sel = 2'b10; enable_lvl = 1'b1;
        start_run();
        zc_at(1537);
        check("R5 full before three quarters", exp_out(2'b10, 1537, 1'b1));
        zc_at(1538);
        check("R5 reduced at three quarters", exp_out(2'b10, 1538, 1'b1));
        zc_at(2049);
        check("R6 on before expiry", exp_out(2'b10, 2049, 1'b1));
        zc_at(2050);
        check("R6 off at expiry", exp_out(2'b10, 2050, 1'b1));

        // R8 retrigger restarts
        start_run();
        zc_at(1000);
        check("R8 first run full", 2'b11);
        start_run();
        zc_at(1200);
        check("R8 restarted run still full", 2'b11);
        zc_at(2060);
        check("R8 restarted run ends", 2'b00);

        // R3 prescale and tick gating
        prescale = 8'd1;
        start_run();
        zc_at(3060);
        check("R3 prescale full", 2'b11);
        zc_at(3090);
        check("R3 prescale reduced", 2'b10);
        zc_at(4090);
        check("R3 prescale still on", 2'b10);
        zc_at(4110);
        check("R3 prescale expired", 2'b00);
        prescale = 8'd0;
        start_run();
        osc_tick = 1'b0;
        zc_at(3000);
        check("R3 no ticks no progress", 2'b11);
        osc_tick = 1'b1;
        zc_at(5100);
        check("R3 ticks resume to expiry", 2'b00);

        // R1/R10 power drop and re-arm
        mode_sel = 2'b01;
        start_run();
        zc_at(50);
        check("R4 static on", 2'b11);
        pwr_good = 1'b0;
        @(negedge clk);
        check("R1 power drop clears", 2'b00);
        step(4);
        pwr_good = 1'b1;
        @(negedge clk);
        el = 0;
        zc_at(20);
        check("R10 re-armed boot run", 2'b11);
        zc_at(2100);
        check("R10 re-armed run ends", 2'b00);

        // R7 follow-enable mode
        mode_sel = 2'b00; enable_lvl = 1'b1;
        zc_at(el + 5);
        check("R7 enable alone reduced", 2'b10);
        start_run();
        zc_at(100);
        check("R7 triggered full", 2'b11);
        enable_lvl = 1'b0;
        zc_at(210);
        check("R7 enable loss off", 2'b00);
        enable_lvl = 1'b1;
        zc_at(230);
        check("R7 run aborted stays reduced", 2'b10);
        start_run();
        zc_at(2100);
        check("R7 expiry with enable stays reduced", exp_out(2'b00, 2100, 1'b1));
        enable_lvl = 1'b0;
        zc_at(el + 4);
        check("R7 off after enable drop", 2'b00);

        // Random strobe positions across modes
        for (int r = 0; r < 6; r++) begin
            case ($urandom_range(2))
                0:       m = 2'b00;
                1:       m = 2'b01;
                default: m = 2'b10;
            endcase
            mode_sel = m;
            enable_lvl = 1'b1;
            start_run();
            k = 2;
            for (int s = 0; s < 4; s++) begin
                k = k + 4 + $urandom_range(600);
                if ((k > 1533 && k < 1543) || (k > 2044 && k < 2054)) k = k + 12;
                zc_at(k);
                check(m == 2'b01 ? "R4 random" : (m == 2'b10 ? "R6 random" : "R5 random"),
                      exp_out(m, k, 1'b1));
            end
            enable_lvl = 1'b0;
            zc_at((el > 2060 ? el : 2060) + 4);
            check("R2 random run ends off", 2'b00);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule